// File: doc/BRIEF.md
# Delay-Line Timestamp Encoder

This block turns one sampled snapshot of a tapped delay line into a raw event word. Every sample clock it receives the tap outputs as a thermometer vector, a hit strobe and the current value of a wide, free-running coarse cycle count. On a hit it works out the fine bin index by counting the ones in the snapshot, which keeps isolated bubbles from causing a large error. It then pairs that index with the coarse count that was presented in the same cycle.

The ones count runs in two pipeline stages. The first stage counts ones inside each group of taps. The second stage adds the group totals. The coarse value travels through the same stages, so the two fields of an event always belong together. Finished events enter a small FIFO and leave it on a valid/ready stream. A snapshot that holds no ones, or holds nothing but ones, still produces an event, but that event is marked as invalid. If an event arrives while the FIFO is full, it is discarded and a sticky drop flag is raised.

Top module: `tdl_stamp_enc`

## Requirements
- R1: The fine field of each event equals the number of ones in the tap snapshot sampled with the hit. This holds for pure thermometer codes and for codes that contain bubbles.
- R2: The event word is 56 bits wide. The coarse value sits in bits 55:8 and the fine index in bits 7:0.
- R3: The coarse field equals the `coarse_i` value sampled in the same cycle as the hit. This includes the all-ones value 2^48-1.
- R4: With the FIFO empty, an event becomes visible on `evt_valid_o` after the third rising edge, counting the edge that samples the hit. It is not visible before then.
- R5: `evt_bad_o` is 1 exactly when the snapshot was all zeros or all ones. Such an event is still emitted, with fine field 0 or 144.
- R6: A cycle with `hit_i` low produces no event, whatever the taps show.
- R7: While `evt_ready_i` is low, the output word and flag hold steady. Up to 4 events are kept and later delivered in arrival order.
- R8: An event that arrives while all 4 FIFO entries are occupied, with no pop in that cycle, is discarded. When that happens `drop_o` goes to 1 and stays at 1 until reset.
- R9: After reset, `evt_valid_o` and `drop_o` are 0.
- R10: Hits on consecutive cycles with `evt_ready_i` high are all delivered, one word per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 1 | Snapshot holds a captured hit |
| taps_i | input | 144 | Thermometer snapshot of the delay-line taps |
| coarse_i | input | 48 | Free-running coarse cycle count |
| evt_ready_i | input | 1 | Downstream accepts the current word |
| evt_valid_o | output | 1 | An event word is presented |
| evt_word_o | output | 56 | Coarse and fine fields of the event |
| evt_bad_o | output | 1 | Event came from an all-zero or all-one snapshot |
| drop_o | output | 1 | Sticky: at least one event was lost to overflow |

## Verification
Several properties are checked on every cycle:
- A stalled word stays stable.
- The drop flag stays set once raised.
- The fine index never exceeds the tap count.
- The invalid flag agrees with a fine index at one of the two ends of the range.

Other behaviours show up only in the bench scenarios:
- That the fine index is the exact ones count.
- That the coarse field lines up with the hit's cycle.
- The pipeline latency.
- FIFO ordering.
- Which specific event is lost on overflow.

The bench covers these through a sweep of every thermometer length from 0 to 144, bubbled variants of those codes, and stall and overflow sequences.

// File: rtl/tdl_enc_pkg.sv
package tdl_enc_pkg;
   localparam int DEF_TAPS     = 144;
   localparam int DEF_GROUP    = 4;
   localparam int DEF_COARSE_W = 48;
   localparam int DEF_FINE_W   = 8;
   localparam int DEF_DEPTH    = 4;

   function automatic int cnt_width(input int n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/tdl_group_ones.sv
module tdl_group_ones #(
   parameter int N  = 4,
   parameter int CW = 3
) (
   input  logic [N-1:0]  bits_i,
   output logic [CW-1:0] cnt_o
);
   always_comb begin
      cnt_o = '0;
      for (int b = 0; b < N; b++)
         cnt_o = cnt_o + CW'(bits_i[b]);
   end
endmodule

// File: rtl/tdl_ones_sum.sv
module tdl_ones_sum #(
   parameter int NGRP = 36,
   parameter int GW   = 3,
   parameter int OW   = 8
) (
   input  logic [NGRP*GW-1:0] cnts_i,
   output logic [OW-1:0]      sum_o
);
   always_comb begin
      sum_o = '0;
      for (int g = 0; g < NGRP; g++)
         sum_o = sum_o + OW'(cnts_i[g*GW +: GW]);
   end
endmodule

// File: rtl/tdl_evt_fifo.sv
module tdl_evt_fifo #(
   parameter int W     = 57,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] data_i,
   input  logic         pop_i,
   output logic         nempty_o,
   output logic [W-1:0] data_o,
   output logic         lost_o
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] rd_q, wr_q;
   logic [CW-1:0] cnt_q;
   logic          full, do_pop, do_push;

   assign full     = (cnt_q == CW'(DEPTH));
   assign nempty_o = (cnt_q != '0);
   assign do_pop   = pop_i && nempty_o;
   assign do_push  = push_i && (!full || do_pop);
   assign data_o   = mem_q[rd_q];
   assign lost_o   = push_i && full && !do_pop;

   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= nxt(wr_q);
         if (do_pop)  rd_q <= nxt(rd_q);
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wr_q] <= data_i;
   end
endmodule

// File: rtl/tdl_stamp_enc.sv
module tdl_stamp_enc
   import tdl_enc_pkg::*;
#(
   parameter int TAPS     = DEF_TAPS,
   parameter int GROUP    = DEF_GROUP,
   parameter int COARSE_W = DEF_COARSE_W,
   parameter int FINE_W   = DEF_FINE_W,
   parameter int DEPTH    = DEF_DEPTH
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       hit_i,
   input  logic [TAPS-1:0]            taps_i,
   input  logic [COARSE_W-1:0]        coarse_i,
   input  logic                       evt_ready_i,
   output logic                       evt_valid_o,
   output logic [COARSE_W+FINE_W-1:0] evt_word_o,
   output logic                       evt_bad_o,
   output logic                       drop_o
);
   localparam int NGRP   = TAPS / GROUP;
   localparam int GW     = cnt_width(GROUP);
   localparam int WORD_W = COARSE_W + FINE_W;
   localparam int ENT_W  = WORD_W + 1;

   generate
      if (TAPS % GROUP != 0) begin : g_bad_group
         $error("TAPS must be a multiple of GROUP");
      end
      if (cnt_width(TAPS) > FINE_W) begin : g_bad_fine
         $error("FINE_W too narrow for TAPS");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("DEPTH must be at least 1");
      end
   endgenerate

   // stage 1: per-group counts
   logic [NGRP*GW-1:0] grp_cnt;
   generate
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         tdl_group_ones #(.N(GROUP), .CW(GW)) cnt_i (
            .bits_i (taps_i[g*GROUP +: GROUP]),
            .cnt_o  (grp_cnt[g*GW +: GW])
         );
      end
   endgenerate

   logic                s1_hit_q, s1_zero_q, s1_ones_q;
   logic [NGRP*GW-1:0]  s1_cnt_q;
   logic [COARSE_W-1:0] s1_coarse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_hit_q    <= 1'b0;
         s1_zero_q   <= 1'b0;
         s1_ones_q   <= 1'b0;
         s1_cnt_q    <= '0;
         s1_coarse_q <= '0;
      end else begin
         s1_hit_q <= hit_i;
         if (hit_i) begin
            s1_zero_q   <= ~|taps_i;
            s1_ones_q   <= &taps_i;
            s1_cnt_q    <= grp_cnt;
            s1_coarse_q <= coarse_i;
         end
      end
   end

   // stage 2: add group totals
   logic [FINE_W-1:0] fine_sum;
   tdl_ones_sum #(.NGRP(NGRP), .GW(GW), .OW(FINE_W)) sum_i (
      .cnts_i (s1_cnt_q),
      .sum_o  (fine_sum)
   );

   logic             s2_vld_q;
   logic [ENT_W-1:0] s2_ent_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_vld_q <= 1'b0;
         s2_ent_q <= '0;
      end else begin
         s2_vld_q <= s1_hit_q;
         if (s1_hit_q)
            s2_ent_q <= {s1_zero_q | s1_ones_q, s1_coarse_q, fine_sum};
      end
   end

   // output buffer
   logic [ENT_W-1:0] head;
   logic             lost, drop_q;

   tdl_evt_fifo #(.W(ENT_W), .DEPTH(DEPTH)) fifo_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_i   (s2_vld_q),
      .data_i   (s2_ent_q),
      .pop_i    (evt_ready_i),
      .nempty_o (evt_valid_o),
      .data_o   (head),
      .lost_o   (lost)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    drop_q <= 1'b0;
      else if (lost) drop_q <= 1'b1;
   end

   assign evt_word_o = head[WORD_W-1:0];
   assign evt_bad_o  = head[WORD_W];
   assign drop_o     = drop_q;
endmodule

// File: rtl/tdl_stamp_enc_chk.sv
module tdl_stamp_enc_chk #(
   parameter int TAPS     = 144,
   parameter int COARSE_W = 48,
   parameter int FINE_W   = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       evt_ready_i,
   input logic                       evt_valid_o,
   input logic [COARSE_W+FINE_W-1:0] evt_word_o,
   input logic                       evt_bad_o,
   input logic                       drop_o
);
   logic [FINE_W-1:0] fine;
   assign fine = evt_word_o[FINE_W-1:0];

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid_o && !evt_ready_i |=> evt_valid_o && $stable(evt_word_o) && $stable(evt_bad_o));

   assert_drop_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o |=> drop_o);

   assert_fine_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid_o |-> (32'(fine) <= TAPS));

   assert_bad_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid_o && evt_bad_o |-> (fine == '0 || 32'(fine) == TAPS));

   assert_good_inner_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid_o && !evt_bad_o |-> (fine != '0 && 32'(fine) != TAPS));
endmodule

bind tdl_stamp_enc tdl_stamp_enc_chk #(
   .TAPS(TAPS), .COARSE_W(COARSE_W), .FINE_W(FINE_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_ready_i (evt_ready_i),
   .evt_valid_o (evt_valid_o),
   .evt_word_o  (evt_word_o),
   .evt_bad_o   (evt_bad_o),
   .drop_o      (drop_o)
);

// File: tb/tdl_stamp_enc_tb_top.sv
module tdl_stamp_enc_tb_top;
   localparam int TAPS = 144;
   localparam int CW   = 48;
   localparam int FW   = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hit_i = 1'b0;
   logic [TAPS-1:0] taps_i = '0;
   logic [CW-1:0] coarse_i = '0;
   logic          evt_ready_i = 1'b0;
   logic          evt_valid_o, evt_bad_o, drop_o;
   logic [CW+FW-1:0] evt_word_o;

   int checks = 0;
   int fails  = 0;
   logic [CW+FW:0] exp_q[$];
   logic mon_on = 1'b0;

   always #2 clk = ~clk;

   tdl_stamp_enc dut_i (
      .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .taps_i(taps_i),
      .coarse_i(coarse_i), .evt_ready_i(evt_ready_i),
      .evt_valid_o(evt_valid_o), .evt_word_o(evt_word_o),
      .evt_bad_o(evt_bad_o), .drop_o(drop_o)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [TAPS-1:0] thermo(input int n);
      return (n == 0) ? '0 : ({TAPS{1'b1}} >> (TAPS - n));
   endfunction

   // one hit; expected entry is {bad, coarse, fine}
   task automatic send(input logic [TAPS-1:0] t, input int n, input logic [CW-1:0] c, input bit kept);
      @(negedge clk);
      hit_i = 1'b1; taps_i = t; coarse_i = c;
      if (kept) exp_q.push_back({(n == 0 || n == TAPS), c, FW'(n)});
   endtask

   task automatic idle(input int cyc);
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         hit_i = 1'b0; taps_i = {$urandom, $urandom, $urandom, $urandom, $urandom};
         coarse_i = coarse_i + 1'b1;
      end
   endtask

   // monitor: R1 R2 R3 R5 R7 R10 ordering and field checks
   always @(negedge clk) begin
      #1;
      if (mon_on && evt_valid_o) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected event", 64'(evt_word_o), 64'h0);
         end else begin
            check(evt_word_o[FW-1:0] == exp_q[0][FW-1:0], "R1 fine",
                  64'(evt_word_o[FW-1:0]), 64'(exp_q[0][FW-1:0]));
            check(evt_word_o[CW+FW-1:FW] == exp_q[0][CW+FW-1:FW], "R2/R3 coarse",
                  64'(evt_word_o[CW+FW-1:FW]), 64'(exp_q[0][CW+FW-1:FW]));
            check(evt_bad_o == exp_q[0][CW+FW], "R5 bad flag",
                  64'(evt_bad_o), 64'(exp_q[0][CW+FW]));
            if (evt_ready_i) void'(exp_q.pop_front());
         end
      end
   end

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check(evt_valid_o == 1'b0, "R9 valid after reset", 64'(evt_valid_o), 0);
      check(drop_o == 1'b0, "R9 drop after reset", 64'(drop_o), 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      idle(3);

      // R4 latency with ready low
      send(thermo(50), 50, 48'h1234_5678_9ABC, 1'b1);
      @(negedge clk); hit_i = 1'b0;
      #1 check(evt_valid_o == 1'b0, "R4 not yet after edge 1", 64'(evt_valid_o), 0);
      @(negedge clk); #1;
      check(evt_valid_o == 1'b0, "R4 not yet after edge 2", 64'(evt_valid_o), 0);
      @(negedge clk); #1;
      check(evt_valid_o == 1'b1, "R4 visible after edge 3", 64'(evt_valid_o), 1);
      check(evt_word_o == {48'h1234_5678_9ABC, 8'd50}, "R2 word layout",
            64'(evt_word_o), {8'h0, 48'h1234_5678_9ABC, 8'd50});
      evt_ready_i = 1'b1;
      idle(4);

      // R6 no hit -> no event
      idle(20);
      check(exp_q.size() == 0 && evt_valid_o == 1'b0, "R6 idle no event", 64'(evt_valid_o), 0);

      // R1 R5 R10 sweep of every thermometer length, back to back
      for (int n = 0; n <= TAPS; n++)
         send(thermo(n), n, CW'(1000 + n), 1'b1);
      idle(6);
      // R1 bubbled codes
      for (int n = 3; n < TAPS - 2; n++) begin
         logic [TAPS-1:0] t;
         t = thermo(n);
         t[n-2] = 1'b0; t[n+1] = 1'b1;
         send(t, n, CW'(5000 + n), 1'b1);
      end
      for (int n = 5; n < TAPS - 5; n += 7) begin
         logic [TAPS-1:0] t;
         t = thermo(n);
         t[n-3] = 1'b0; t[n-1] = 1'b0; t[n+2] = 1'b1; t[n+4] = 1'b1;
         send(t, n, CW'(7000 + n), 1'b1);
      end
      // R3 maximum coarse value
      send(thermo(77), 77, {CW{1'b1}}, 1'b1);
      idle(6);
      check(exp_q.size() == 0, "R10 all delivered", 64'(exp_q.size()), 0);
      check(drop_o == 1'b0, "R8 no drop yet", 64'(drop_o), 0);

      // R7 R8 stall then overflow
      @(negedge clk); evt_ready_i = 1'b0;
      for (int k = 0; k < 4; k++) send(thermo(10 + k), 10 + k, CW'(900 + k), 1'b1);
      send(thermo(99), 99, CW'(999), 1'b0);
      idle(8);
      check(exp_q.size() == 4, "R7 four held", 64'(exp_q.size()), 4);
      check(evt_word_o == {CW'(900), 8'd10}, "R7 head is oldest",
            64'(evt_word_o), {8'h0, CW'(900), 8'd10});
      check(drop_o == 1'b1, "R8 drop set", 64'(drop_o), 1);
      evt_ready_i = 1'b1;
      idle(8);
      check(exp_q.size() == 0 && evt_valid_o == 1'b0, "R8 lost event absent",
            64'(exp_q.size()), 0);
      check(drop_o == 1'b1, "R8 drop sticky", 64'(drop_o), 1);

      // R9 reset clears drop
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); #1;
      check(drop_o == 1'b0 && evt_valid_o == 1'b0, "R9 reset clears", 64'(drop_o), 0);
      rst_n = 1'b1;
      idle(2);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule